// File: doc/BRIEF.md
# Two-Level Wide Magnitude Comparator

This block is purely combinational. It takes two unsigned operands of up to 24 bits and reports whether the first is greater than, equal to, or less than the second. It does not pass a result along a chain of narrow comparators. Instead it splits the operands into slices and compares every slice at the same time in a first rank of 4-bit comparator cells. A second-level cell then reduces the slice verdicts into the final answer.

Every first-rank cell except the lowest uses its cascade inputs as one extra data bit. The bit from the first operand goes to the greater input, the matching bit from the second operand goes to the less input, and the equal input is held at 0. These cells therefore cover five bits each. Their greater and less outputs form the operand pairs of the final cell, and the more significant slices occupy the more significant positions.

The lowest slice (bits 3..0) is a plain 4-bit cell. Its cascade inputs are tied to the "no lower stage" pattern. Its three outputs feed the cascade inputs of the final cell. If the operand width parameter is below 24, both operands are zero-extended to 24 bits before slicing.

Top module: `wide_mag_cmp`

## Requirements
- R1: Exactly one of `gt_o`, `eq_o`, `lt_o` is 1 for every input pair.
- R2: `eq_o` is 1 exactly when `a_i` equals `b_i`, including both operands 0.
- R3: `gt_o` is 1 exactly when `a_i` is greater than `b_i` as unsigned numbers.
- R4: `lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned numbers.
- R5: Operands that differ only in bit 0 give `gt_o` when `a_i[0]` is 1 and `lt_o` when `b_i[0]` is 1.
- R6: A difference in the top bit (bit W-1) decides the result whatever the lower bits hold.
- R7: A difference at bit 4, 9, 14 or 19 decides the result when all higher bits match. These bits are carried on the cascade inputs of the first-rank cells, and they must outweigh every lower bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i  | input     | W     | First unsigned operand |
| b_i  | input     | W     | Second unsigned operand |
| gt_o | output    | 1     | First operand is greater |
| eq_o | output    | 1     | Operands are equal |
| lt_o | output    | 1     | First operand is less |

## Verification
The checker's assertions are immediate. They assume the operands are settled, two-valued numbers whenever they are evaluated. They check the outputs against the plain relational operators, so they presume no X or Z on `a_i` and `b_i`.

The bench changes the operands only on the falling clock edge. It always drives fully defined vectors, masked to W bits. Results are read half a cycle later, after the combinational paths have settled.

// File: rtl/wide_mag_cmp.sv
module wide_mag_cmp #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         eq_o,
  output logic         lt_o
);
  localparam int PW  = 24;
  localparam int NUP = 4;

  function automatic logic [1:0] cell_gl(input logic [3:0] a, input logic [3:0] b,
                                         input logic cgt, input logic ceq, input logic clt);
    if (a > b)    return 2'b10;
    else if (a < b) return 2'b01;
    else if (ceq) return 2'b00;
    else          return {~clt, ~cgt};
  endfunction

  function automatic logic cell_eq(input logic [3:0] a, input logic [3:0] b, input logic ceq);
    return (a == b) && ceq;
  endfunction

  logic [PW-1:0]  ap, bp;
  logic [NUP:0]   sgt, slt;
  logic           seq0;
  logic [NUP-1:0] fa, fb;

  assign ap = PW'(a_i);
  assign bp = PW'(b_i);

  assign {sgt[0], slt[0]} = cell_gl(ap[3:0], bp[3:0], 1'b0, 1'b1, 1'b0);
  assign seq0             = cell_eq(ap[3:0], bp[3:0], 1'b1);

  for (genvar k = 1; k <= NUP; k++) begin : g_rank
    assign {sgt[k], slt[k]} = cell_gl(ap[5*k+3 -: 4], bp[5*k+3 -: 4],
                                      ap[5*k-1], 1'b0, bp[5*k-1]);
    assign fa[k-1] = sgt[k];
    assign fb[k-1] = slt[k];
  end

  assign {gt_o, lt_o} = cell_gl(fa, fb, sgt[0], seq0, slt[0]);
  assign eq_o         = cell_eq(fa, fb, seq0);
endmodule

// File: rtl/wide_mag_cmp_chk.sv
module wide_mag_cmp_chk #(
  parameter int W = 24
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         gt_o,
  input logic         eq_o,
  input logic         lt_o
);
  always_comb begin
    AST_ONE_RESULT: assert ($onehot({gt_o, eq_o, lt_o})); // R1
    AST_EQ_MATCH:   assert (eq_o == (a_i == b_i));        // R2
    AST_GT_MATCH:   assert (gt_o == (a_i > b_i));         // R3
    AST_LT_MATCH:   assert (lt_o == (a_i < b_i));         // R4
  end
endmodule

bind wide_mag_cmp wide_mag_cmp_chk #(.W(W)) chk_i (
  .a_i(a_i), .b_i(b_i), .gt_o(gt_o), .eq_o(eq_o), .lt_o(lt_o)
);

// File: tb/wide_mag_cmp_tb_top.sv
module wide_mag_cmp_tb_top;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b;
  logic gt, eq, lt;

  wide_mag_cmp #(.W(W)) dut_i (.a_i(a), .b_i(b), .gt_o(gt), .eq_o(eq), .lt_o(lt));

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb, input string tag);
    @(negedge clk);
    a = va;
    b = vb;
    exp_q.push_back({va > vb, va == vb, va < vb});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({gt, eq, lt} !== e) begin
        errors++;
        $display("FAIL %s a=%h b=%h got gt/eq/lt=%b expected %b", t, a, b, {gt, eq, lt}, e);
      end
    end
  end

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if ({gt, eq, lt} !== 3'b010) begin
      errors++;
      $display("FAIL R2 zero operands got %b expected 010", {gt, eq, lt});
    end
    rst_n = 1'b1;

    drive(24'h000000, 24'h000000, "R2 all zero");
    drive(24'hFFFFFF, 24'hFFFFFF, "R2 all ones");
    drive(24'h5A5A5A, 24'h5A5A5A, "R2 pattern equal");
    drive(24'h000001, 24'h000000, "R5 lsb a");
    drive(24'h000000, 24'h000001, "R5 lsb b");
    drive(24'hABCDEF, 24'hABCDEE, "R5 lsb a high bits set");
    drive(24'h800000, 24'h7FFFFF, "R6 msb a");
    drive(24'h7FFFFF, 24'h800000, "R6 msb b");
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] base;
      int p;
      p = 5 * i + 4;
      base = W'($urandom) & ~(W'(1) << p);
      drive(base | (W'(1) << p), base & ~((W'(1) << p) - 1) | ((W'(1) << p) - 1), "R7 ext bit a");
      drive(base & ~((W'(1) << p) - 1) | ((W'(1) << p) - 1), base | (W'(1) << p), "R7 ext bit b");
    end
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      drive(v, v ^ (W'(1) << i), "R3 R4 single bit flip");
    end
    for (int i = 0; i < 300; i++) begin
      drive(W'($urandom), W'($urandom), "R1 R3 R4 random");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule